// File: doc/BRIEF.md
# AXI4-Stream Video Framing Checker

This block is a passive monitor that sits beside an AXI4-Stream video slave port and watches its handshakes. It never drives the stream. On every accepted transfer it tracks the position of the pixel within the current line and the line within the current frame. It compares these positions against a programmed active width and height and flags four framing faults: a line that ends too soon, a line that runs past the width, a frame that restarts too soon and a frame that runs past the height.

Faults land in a four-bit sticky register that software clears by writing ones. A summary slave-error output is the OR of the sticky bits. A nine-bit event vector gives unheld, single-transfer pulses for frame start, frame completion, the pixel and line terminal counts, a per-transfer error summary and each individual fault. The vector is meant to feed an interrupt controller or a debug counter bank.

Top module: `vfc_framing_checker`

## Requirements
- R1: A transfer is accepted only at a rising clock edge where s_tvalid, s_tready and ce are all high and rst is low. Without such a transfer every bit of evt is 0 and the position counters hold their values.
- R2: An accepted transfer with s_tlast high whose 1-based pixel position in the line is below cfg_width raises the end-of-line-early fault: err_flags bit 0 and evt bit 5.
- R3: The first accepted transfer at 1-based position cfg_width+1 with s_tlast low raises the end-of-line-late fault: err_flags bit 1 and evt bit 6. This happens once per line.
- R4: An accepted s_tuser transfer after an earlier start-of-frame, when fewer than cfg_height lines have ended since that start, raises the start-of-frame-early fault: err_flags bit 2 and evt bit 7.
- R5: The first accepted transfer without s_tuser that would begin line cfg_height+1 of a frame raises the start-of-frame-late fault: err_flags bit 3 and evt bit 8. This happens once per frame.
- R6: Each err_flags bit is sticky from the clock edge after its fault. On an edge with ce high and clr_wr high, a 1 in clr_mask clears that bit. A fault on the same edge wins over the clear. slave_err is high exactly when any err_flags bit is set.
- R7: The evt bits are combinational and valid only in the cycle of an accepted transfer. Bit 0 is a start-of-frame transfer. Bit 1 is the s_tlast transfer of line cfg_height (1-based). Bit 2 is the pixel at position cfg_width. Bit 3 is any pixel of line cfg_height. Bit 4 is the OR of bits 5 to 8.
- R8: Each accepted s_tuser transfer is pixel 1 of line 1, whatever faults were raised. Transfers before the first start-of-frame after reset raise no evt bit and no fault.
- R9: With rst high, err_flags, slave_err and the position state are cleared at the next rising edge regardless of ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; low freezes the monitor |
| s_tvalid | input | 1 | Observed stream valid |
| s_tready | input | 1 | Observed stream ready |
| s_tuser | input | 1 | Observed start-of-frame marker |
| s_tlast | input | 1 | Observed end-of-line marker |
| cfg_width | input | CNT_W | Active pixels per line (at least 1) |
| cfg_height | input | CNT_W | Active lines per frame (at least 1) |
| clr_wr | input | 1 | Write strobe for clearing error flags |
| clr_mask | input | 4 | Write-1-to-clear mask for err_flags |
| err_flags | output | 4 | Sticky faults: 0 line early, 1 line late, 2 frame early, 3 frame late |
| slave_err | output | 1 | OR of err_flags |
| evt | output | 9 | Unheld event pulses, bit order as in R7 |

## Verification
The stream is driven with clean frames, a short line, an over-long line, a frame cut short by a new start marker and a frame with one line too many. A clean frame shows that the terminal-count and completion events land on the right pixels while no fault bits are set. Each faulty shape must set exactly one fault kind, and the late faults must fire once even when the excess continues. Stalls with ce low or s_tready low in the middle of a line show that the position counters do not move. Stray pixels before the first start marker must stay silent. Partial clears and a mid-run reset show that the sticky bits are independent of each other.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    localparam int NUM_FAULTS = 4;
    localparam int NUM_EVENTS = 9;

    // Fault set: bit 0 line early, 1 line late, 2 frame early, 3 frame late
    typedef struct packed {
        logic frame_late;
        logic frame_early;
        logic line_late;
        logic line_early;
    } fault_t;

    // Event vector: packed LSB first is frame_start
    typedef struct packed {
        fault_t faults;
        logic   any_fault;
        logic   last_line;
        logic   last_pixel;
        logic   frame_done;
        logic   frame_start;
    } event_t;

endpackage

// File: rtl/vfc_position.sv
module vfc_position #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer,
    input  logic             sof,
    input  logic             eol,
    output logic [CNT_W-1:0] pix_idx,
    output logic [CNT_W-1:0] line_idx,
    output logic [CNT_W-1:0] lines_done,
    output logic             framed,
    output logic             was_framed
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pix_q;
    logic [CNT_W-1:0] line_q;
    logic             in_frame_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    // A start marker repositions the current transfer to pixel 0 of line 0
    assign pix_idx    = sof ? '0 : pix_q;
    assign line_idx   = sof ? '0 : line_q;
    assign lines_done = line_q;
    assign framed     = sof | in_frame_q;
    assign was_framed = in_frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q      <= '0;
            line_q     <= '0;
            in_frame_q <= 1'b0;
        end else if (xfer) begin
            in_frame_q <= in_frame_q | sof;
            if (eol) begin
                pix_q  <= '0;
                line_q <= sat_inc(line_idx);
            end else begin
                pix_q  <= sat_inc(pix_idx);
                line_q <= line_idx;
            end
        end
    end

endmodule

// File: rtl/vfc_rules.sv
module vfc_rules
    import vfc_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             xfer,
    input  logic             sof,
    input  logic             eol,
    input  logic             framed,
    input  logic             was_framed,
    input  logic [CNT_W-1:0] pix_idx,
    input  logic [CNT_W-1:0] line_idx,
    input  logic [CNT_W-1:0] lines_done,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] height,
    output fault_t           faults,
    output event_t           events
);

    localparam int EXT_W = CNT_W + 1;

    logic             live;
    logic [EXT_W-1:0] pix_pos;
    logic [EXT_W-1:0] width_x;
    logic [EXT_W-1:0] height_x;
    logic [EXT_W-1:0] line_last_x;
    logic [EXT_W-1:0] pix_last_x;

    assign live        = xfer & framed;
    assign pix_pos     = {1'b0, pix_idx} + 1'b1;
    assign width_x     = {1'b0, width};
    assign height_x    = {1'b0, height};
    assign line_last_x = height_x - 1'b1;
    assign pix_last_x  = width_x - 1'b1;

    always_comb begin
        faults.line_early  = live & eol & (pix_pos < width_x);
        faults.line_late   = live & ~eol & ({1'b0, pix_idx} == width_x);
        faults.frame_early = live & sof & was_framed & ({1'b0, lines_done} < height_x);
        faults.frame_late  = live & ~sof & was_framed & (pix_idx == '0)
                             & ({1'b0, line_idx} == height_x);

        events.faults      = faults;
        events.any_fault   = |faults;
        events.frame_start = live & sof;
        events.last_line   = live & ({1'b0, line_idx} == line_last_x);
        events.last_pixel  = live & ({1'b0, pix_idx} == pix_last_x);
        events.frame_done  = live & eol & ({1'b0, line_idx} == line_last_x);
    end

endmodule

// File: rtl/vfc_sticky.sv
module vfc_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [N-1:0] set_in,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_in[i]) begin
                bit_q <= 1'b1;
            end else if (ce && clr_wr && clr_mask[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[i] = bit_q;
    end

endmodule

// File: rtl/vfc_framing_checker.sv
module vfc_framing_checker
    import vfc_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic                  s_tvalid,
    input  logic                  s_tready,
    input  logic                  s_tuser,
    input  logic                  s_tlast,
    input  logic [CNT_W-1:0]      cfg_width,
    input  logic [CNT_W-1:0]      cfg_height,
    input  logic                  clr_wr,
    input  logic [NUM_FAULTS-1:0] clr_mask,
    output logic [NUM_FAULTS-1:0] err_flags,
    output logic                  slave_err,
    output logic [NUM_EVENTS-1:0] evt
);

    logic             xfer;
    logic [CNT_W-1:0] pix_idx;
    logic [CNT_W-1:0] line_idx;
    logic [CNT_W-1:0] lines_done;
    logic             framed;
    logic             was_framed;
    fault_t           faults;
    event_t           events;

    assign xfer = s_tvalid & s_tready & ce & ~rst;

    vfc_position #(.CNT_W(CNT_W)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .xfer       (xfer),
        .sof        (s_tuser),
        .eol        (s_tlast),
        .pix_idx    (pix_idx),
        .line_idx   (line_idx),
        .lines_done (lines_done),
        .framed     (framed),
        .was_framed (was_framed)
    );

    vfc_rules #(.CNT_W(CNT_W)) u_rules (
        .xfer       (xfer),
        .sof        (s_tuser),
        .eol        (s_tlast),
        .framed     (framed),
        .was_framed (was_framed),
        .pix_idx    (pix_idx),
        .line_idx   (line_idx),
        .lines_done (lines_done),
        .width      (cfg_width),
        .height     (cfg_height),
        .faults     (faults),
        .events     (events)
    );

    vfc_sticky #(.N(NUM_FAULTS)) u_sticky (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .set_in   (faults),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags    (err_flags)
    );

    assign slave_err = |err_flags;
    assign evt       = events;

endmodule

// File: rtl/vfc_framing_checker_sva.sv
module vfc_framing_checker_sva #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic             s_tuser,
    input logic             s_tlast,
    input logic [CNT_W-1:0] cfg_width,
    input logic [CNT_W-1:0] cfg_height,
    input logic             clr_wr,
    input logic [3:0]       clr_mask,
    input logic [3:0]       err_flags,
    input logic             slave_err,
    input logic [8:0]       evt
);

    a_r1_quiet_without_transfer: assert property (@(posedge clk) disable iff (rst)
        !(s_tvalid && s_tready && ce) |-> (evt == '0));

    a_r2_line_early_latches: assert property (@(posedge clk) disable iff (rst)
        evt[5] |=> err_flags[0]);

    a_r3_line_late_not_repeated: assert property (@(posedge clk) disable iff (rst)
        evt[6] |=> !evt[6]);

    a_r5_frame_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt[8:7]));

    a_r6_flags_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
        (ce && !clr_wr) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    a_r7_start_needs_marker: assert property (@(posedge clk) disable iff (rst)
        evt[0] |-> (s_tuser && s_tvalid && s_tready && ce));

endmodule

bind vfc_framing_checker vfc_framing_checker_sva #(.CNT_W(CNT_W)) u_sva (.*);

// File: tb/tb_vfc_framing_checker.sv
module tb_vfc_framing_checker;

    localparam int CNT_W = 13;
    localparam int W = 4;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1;
    logic s_tvalid = 1'b0;
    logic s_tready = 1'b1;
    logic s_tuser = 1'b0;
    logic s_tlast = 1'b0;
    logic clr_wr = 1'b0;
    logic [3:0] clr_mask = '0;
    logic [CNT_W-1:0] cfg_width = CNT_W'(W);
    logic [CNT_W-1:0] cfg_height = CNT_W'(H);
    logic [3:0] err_flags;
    logic slave_err;
    logic [8:0] evt;

    int checks = 0;
    int fails = 0;
    bit monitor_on = 1'b0;

    logic [8:0] exp_q[$];
    int  m_pix = 0;
    int  m_line = 0;
    bit  m_in = 1'b0;
    logic [3:0] m_err = '0;

    always #5 clk = ~clk;

    vfc_framing_checker #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .ce(ce),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .clr_wr(clr_wr), .clr_mask(clr_mask),
        .err_flags(err_flags), .slave_err(slave_err), .evt(evt)
    );

    // Monitor: pops the expected event vector for every accepted transfer
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (monitor_on) begin
                if (s_tvalid && s_tready && ce) begin
                    logic [8:0] e;
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R7 event for unexpected transfer: got %b exp none", evt);
                    end else begin
                        e = exp_q.pop_front();
                        if (evt !== e) begin
                            fails++;
                            $display("FAIL R7 event vector: got %b exp %b", evt, e);
                        end
                    end
                end else if (evt !== '0) begin
                    checks++;
                    fails++;
                    $display("FAIL R1 event without transfer: got %b exp %b", evt, 9'b0);
                end
            end
        end
    end

    // Driver: one accepted pixel, expected events pushed from the requirement model
    task automatic px(input bit u, input bit l);
        int pi, li;
        bit fr;
        logic [8:0] e;
        pi = u ? 0 : m_pix;
        li = u ? 0 : m_line;
        fr = u | m_in;
        e = '0;
        if (fr) begin
            e[0] = u;
            e[1] = l && (li == H - 1);
            e[2] = (pi == W - 1);
            e[3] = (li == H - 1);
            e[5] = l && (pi + 1 < W);
            e[6] = !l && (pi == W);
            e[7] = u && m_in && (m_line < H);
            e[8] = !u && m_in && (pi == 0) && (li == H);
            e[4] = |e[8:5];
        end
        exp_q.push_back(e);
        m_err = m_err | e[8:5];
        if (u) m_in = 1'b1;
        if (l) begin
            m_pix = 0;
            m_line = li + 1;
        end else begin
            m_pix = pi + 1;
            m_line = li;
        end
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tuser = u;
        s_tlast = l;
        @(posedge clk);
        #1;
        s_tvalid = 1'b0;
        s_tuser = 1'b0;
        s_tlast = 1'b0;
    endtask

    task automatic line(input int n, input bit first_sof);
        for (int i = 0; i < n; i++) px(first_sof && i == 0, i == n - 1);
    endtask

    task automatic check_err(input string tag);
        @(negedge clk);
        #3;
        checks++;
        if (err_flags !== m_err || slave_err !== (|m_err)) begin
            fails++;
            $display("FAIL %s err_flags: got %b/%b exp %b/%b", tag, err_flags, slave_err, m_err, |m_err);
        end
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        clr_wr = 1'b1;
        clr_mask = m;
        @(posedge clk);
        #1;
        clr_wr = 1'b0;
        clr_mask = '0;
        m_err = m_err & ~m;
    endtask

    task automatic run_test();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_err("R9 reset");
        monitor_on = 1'b1;

        // R8: stray pixels before the first start marker are silent
        line(2, 1'b0);
        check_err("R8 pre-frame");

        // Clean frame, then next frame starts on time
        line(W, 1'b1); line(W, 1'b0); line(W, 1'b0);
        check_err("R7 clean frame");

        // R2: short line inside a new frame
        line(W, 1'b1); line(2, 1'b0); line(W, 1'b0);
        check_err("R2 line early");

        // R3: over-long line, flagged once
        line(W, 1'b1); line(W + 2, 1'b0); line(W, 1'b0);
        check_err("R3 line late");

        // R6: clear both line faults
        clear(4'b0011);
        check_err("R6 clear line bits");

        // R4: frame restarted after two lines
        line(W, 1'b1); line(W, 1'b0);
        // R5: next frame with one extra line (plus another, no repeat)
        line(W, 1'b1); line(W, 1'b0); line(W, 1'b0); line(W, 1'b0); line(W, 1'b0);
        check_err("R4 R5 frame faults");

        // R6: partial clear keeps frame-late bit
        clear(4'b0100);
        check_err("R6 partial clear");

        // R6: clear with ce low is ignored
        ce = 1'b0;
        clear(4'b1000);
        m_err[3] = 1'b1;
        ce = 1'b1;
        check_err("R6 clear needs ce");

        // R1: stalls by ce and by ready in mid-line do not move counters
        px(1'b1, 1'b0);
        @(negedge clk); s_tvalid = 1'b1; ce = 1'b0;
        @(posedge clk); #1; s_tvalid = 1'b0; ce = 1'b1;
        px(1'b0, 1'b0);
        @(negedge clk); s_tvalid = 1'b1; s_tready = 1'b0;
        @(posedge clk); #1; s_tvalid = 1'b0; s_tready = 1'b1;
        px(1'b0, 1'b0);
        px(1'b0, 1'b1);
        check_err("R1 stalls");

        // R9: reset mid-run clears flags and position
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        m_err = '0; m_in = 1'b0; m_pix = 0; m_line = 0;
        check_err("R9 mid reset");
        line(W, 1'b0);
        line(W, 1'b1); line(W, 1'b0); line(W, 1'b0);
        check_err("R8 after reset");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 missing transfers: got %0d left exp 0", exp_q.size());
        end
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired: got timeout exp completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule